// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with APB Access

This block is a single 16-bit down-counter that software controls through four word registers on an APB slave port. Software programs a start value, selects one of eight clock-divide ratios, and chooses between two end-of-count behaviours. It then enables the counter. When the count runs out, a sticky status flag is raised. That flag drives the interrupt line and stays set until software writes to the acknowledge register.

Each divided-clock tick moves the counter down by one step. When the count passes from one to zero, the flag is set. On the tick after that, the counter either takes the programmed start value again (periodic mode) or rolls over to the all-ones value and keeps counting down (free-running mode). A write to the start-value register takes effect on the next clock edge. It loads the counter and restarts the divider phase, so software gets a fixed timing reference.

Top module: `apb_tick_timer`

## Requirements
- R1: After reset, all four registers read zero, the counter holds at zero and `irq` is low.
- R2: The start value is read and written at byte offset 0x0, and only bits 15:0 are kept, so the upper bits read as zero. The live count is read at 0x4, and writes to 0x4 leave it unchanged. Offset 0xC is the acknowledge register, which always reads zero.
- R3: The control word at 0x8 has the divide code in bits 4:2, the mode in bit 6 (1 = periodic, 0 = free-running), the enable in bit 7 and the read-only status in bit 8. Bits 1:0, bit 5 and bits 31:9 always read zero.
- R4: Divide code 0 gives a tick on every clock. Codes 1 through 7 give one tick every 16, 256, 2, 8, 32, 128 and 1024 clocks respectively.
- R5: While enable is 0, the count holds its value.
- R6: A write to 0x0 loads the counter with the written value at that clock edge. A write to 0x0 or to 0x8 restarts the divider phase. With the block enabled and ratio N, the count k clocks after a start-value write equals the written value minus floor(k/N), until it reaches zero.
- R7: A tick that takes the count from 1 to 0 sets the status flag in the same clock edge. The flag stays set until it is acknowledged, and `irq` always equals it.
- R8: In periodic mode, the tick after the count reaches zero reloads the start value.
- R9: In free-running mode, the tick after the count reaches zero wraps the count to 0xFFFF.
- R10: A write of any data to 0xC clears the flag. If the count expires in the same cycle as that write, the flag ends up set.
- R11: Every transfer completes with no wait states (`pready` high), and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address; bits 3:2 pick the register |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq | output | 1 | Interrupt, a copy of the sticky status flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 10-bit divider phase. These values cover every ratio up to 1024 and the full 0xFFFF wrap value. Each of the eight divide codes is sampled one clock before its third tick, so an off-by-one error in the divider or a swapped ratio changes the count that is read back. The bench also places an acknowledge write on the exact clock edge of an expiry, to check which of the two wins.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned APB_DW = 32;

    // Bit positions inside the control word; software decodes these.
    localparam int unsigned CW_DIV_LSB  = 2;
    localparam int unsigned CW_MODE_BIT = 6;
    localparam int unsigned CW_EN_BIT   = 7;
    localparam int unsigned CW_STAT_BIT = 8;

    // Register index taken from address bits 3:2.
    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_ACK   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [2:0] div_code;
    } ctrl_t;

    // log2 of the divide ratio for each code; the order is fixed by software.
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        logic [3:0] sh;
        case (code)
            3'd0:    sh = 4'd0;
            3'd1:    sh = 4'd4;
            3'd2:    sh = 4'd8;
            3'd3:    sh = 4'd1;
            3'd4:    sh = 4'd3;
            3'd5:    sh = 4'd5;
            3'd6:    sh = 4'd7;
            default: sh = 4'd10;
        endcase
        return sh;
    endfunction

    function automatic logic [APB_DW-1:0] pack_ctrl(input ctrl_t c, input logic status);
        logic [APB_DW-1:0] w;
        w = '0;
        w[CW_DIV_LSB +: 3] = c.div_code;
        w[CW_MODE_BIT]     = c.periodic;
        w[CW_EN_BIT]       = c.en;
        w[CW_STAT_BIT]     = status;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [APB_DW-1:0] w);
        ctrl_t c;
        c.div_code = w[CW_DIV_LSB +: 3];
        c.periodic = w[CW_MODE_BIT];
        c.en       = w[CW_EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/tt_apb_regs.sv
module tt_apb_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    output logic [APB_DW-1:0] prdata,
    output logic [CNT_W-1:0]  start_q,
    output ctrl_t             ctrl_q,
    output logic              wr_start,
    output logic              wr_ctrl,
    output logic              wr_ack
);

    reg_sel_e sel;
    logic     wr_access;
    logic     rd_access;
    logic     unused_bits;

    assign sel       = reg_sel_e'(paddr[3:2]);
    assign wr_access = psel & penable & pwrite;
    assign rd_access = psel & ~pwrite;

    assign wr_start = wr_access && (sel == REG_START);
    assign wr_ctrl  = wr_access && (sel == REG_CTRL);
    assign wr_ack   = wr_access && (sel == REG_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_start) start_q <= pwdata[CNT_W-1:0];
            if (wr_ctrl)  ctrl_q  <= unpack_ctrl(pwdata);
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_access) begin
            case (sel)
                REG_START: prdata = APB_DW'(start_q);
                REG_COUNT: prdata = APB_DW'(count);
                REG_CTRL:  prdata = pack_ctrl(ctrl_q, status);
                default:   prdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{paddr, pwdata};

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PH_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    import tick_timer_pkg::*;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;

    assign limit = PH_W'((32'd1 << div_shift(div_code)) - 32'd1);
    assign tick  = en && !restart && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (en) begin
            if (tick) phase_q <= '0;
            else      phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            if (count == '0) count <= periodic ? start_val : '1;
            else             count <= count - ONE;
        end
    end

endmodule

// File: rtl/tt_irq_flag.sv
module tt_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/apb_tick_timer.sv
module apb_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PH_W   = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);

    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] count_q;
    ctrl_t            ctrl_q;
    logic             wr_start;
    logic             wr_ctrl;
    logic             wr_ack;
    logic             tick;
    logic             expire;
    logic             status;

    tt_apb_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .count    (count_q),
        .status   (status),
        .prdata   (prdata),
        .start_q  (start_q),
        .ctrl_q   (ctrl_q),
        .wr_start (wr_start),
        .wr_ctrl  (wr_ctrl),
        .wr_ack   (wr_ack)
    );

    tt_prescaler #(.PH_W(PH_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .restart  (wr_start | wr_ctrl),
        .div_code (ctrl_q.div_code),
        .tick     (tick)
    );

    tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_start),
        .load_val  (pwdata[CNT_W-1:0]),
        .tick      (tick),
        .periodic  (ctrl_q.periodic),
        .start_val (start_q),
        .count     (count_q),
        .expire    (expire)
    );

    tt_irq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (wr_ack),
        .flag (status)
    );

    assign irq     = status;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pready,
    input logic             pslverr,
    input logic             irq,
    input logic [31:0]      pwdata,
    input logic             wr_start,
    input logic             wr_ack,
    input logic             tick,
    input logic             en,
    input logic             periodic,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] start_val
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R6: a start-value write lands in the counter at that edge
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> count == $past(pwdata[CNT_W-1:0]));

    // R5: disabled counter holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_start) |=> $stable(count));

    // R7: expiry raises the interrupt
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && count == ONE) |=> irq);

    // R7: flag is sticky until acknowledged
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ack) |=> irq);

    // R8: periodic mode reloads after zero
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0 && periodic) |=> count == $past(start_val));

    // R9: free-running mode wraps to all ones
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0 && !periodic) |=> (&count));

    // R10: acknowledge without a coincident expiry clears
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !(tick && count == ONE)) |=> !irq);

    // R11: zero wait states, no error
    p_apb_r11: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

endmodule

bind apb_tick_timer tt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq       (irq),
    .pwdata    (pwdata),
    .wr_start  (wr_start),
    .wr_ack    (wr_ack),
    .tick      (tick),
    .en        (ctrl_q.en),
    .periodic  (ctrl_q.periodic),
    .count     (count_q),
    .start_val (start_q)
);

// File: tb/tb_apb_tick_timer.sv
module tb_apb_tick_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    apb_tick_timer dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Divide ratio per code, written from the requirement table.
    function automatic int ratio(input int code);
        case (code)
            0: return 1;    1: return 16;  2: return 256; 3: return 2;
            4: return 8;    5: return 32;  6: return 128; default: return 1024;
        endcase
    endfunction

    // Expected count k clocks after a start write of L.
    function automatic logic [31:0] model(input int L, input int k, input int n, input bit per);
        logic [15:0] v = 16'(L);
        for (int i = 0; i < k / n; i++) begin
            if (v == 16'd0) v = per ? 16'(L) : 16'hFFFF;
            else            v = v - 16'd1;
        end
        return {16'd0, v};
    endfunction

    function automatic logic [31:0] cw(input bit en, input bit per, input int code);
        return (32'(en) << 7) | (32'(per) << 6) | (32'(code) << 2);
    endfunction

    // All bus tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int c);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        c = cyc;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output int c);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1; #1;
        d = prdata; c = cyc;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d; int c;
        chk("R1 irq", 32'(irq), 0);
        rd(4'h0, d, c); chk("R1 start", d, 0);
        rd(4'h4, d, c); chk("R1 count", d, 0);
        rd(4'h8, d, c); chk("R1 ctrl", d, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d; int c;
        wr(4'h0, 32'hABCD_1234, c);
        rd(4'h0, d, c); chk("R2 start upper bits", d, 32'h1234);
        wr(4'h4, 32'h5555, c);
        rd(4'h4, d, c); chk("R2 count read-only", d, 32'h1234);
        rd(4'hC, d, c); chk("R2 ack reads zero", d, 0);
        psel = 1'b1; pwrite = 1'b0; paddr = 4'h8;
        @(negedge clk); penable = 1'b1; #1;
        chk("R11 pready", 32'(pready), 1);
        chk("R11 pslverr", 32'(pslverr), 0);
        @(negedge clk); psel = 1'b0; penable = 1'b0;
        wr(4'h8, 32'hFFFF_FFFF, c);
        rd(4'h8, d, c); chk("R3 ctrl pads", d, 32'h0000_00DC);
        wr(4'h8, 0, c);
    endtask

    task automatic t_dividers;
        logic [31:0] d; int cw0, cr;
        for (int code = 0; code < 8; code++) begin
            int n = ratio(code);
            wr(4'h8, cw(1, 0, code), cw0);
            wr(4'h0, 3000, cw0);
            idle(3 * n - 2);
            rd(4'h4, d, cr);
            chk($sformatf("R4 R6 code %0d", code), d, model(3000, cr - cw0, n, 0));
        end
        wr(4'h8, 0, cw0);
    endtask

    task automatic t_hold;
        logic [31:0] d; int c;
        wr(4'h8, cw(0, 1, 0), c);
        wr(4'h0, 77, c);
        idle(20);
        rd(4'h4, d, c); chk("R5 hold while disabled", d, 77);
    endtask

    task automatic t_periodic;
        logic [31:0] d; int c, w, cr;
        wr(4'hC, 0, c);
        chk("R10 ack clears", 32'(irq), 0);
        wr(4'h8, cw(1, 1, 3), c);
        wr(4'h0, 6, w);
        for (int i = 0; i < 200 && irq !== 1'b1; i++) @(negedge clk);
        chk("R7 expiry edge", 32'(cyc - w), 12);
        idle(5);
        rd(4'h4, d, cr); chk("R8 periodic reload", d, model(6, cr - w, 2, 1));
        rd(4'h8, d, c); chk("R7 status bit", d, cw(1, 1, 3) | 32'h100);
        wr(4'h8, 0, c);
    endtask

    task automatic t_free;
        logic [31:0] d; int c, w, cr;
        wr(4'hC, 0, c);
        wr(4'h8, cw(1, 0, 0), c);
        wr(4'h0, 3, w);
        idle(5);
        rd(4'h4, d, cr); chk("R9 wrap to FFFF", d, model(3, cr - w, 1, 0));
        chk("R7 irq after free expiry", 32'(irq), 1);
        wr(4'h8, 0, c);
        wr(4'hC, 32'hDEAD_BEEF, c);
        chk("R10 ack with any data", 32'(irq), 0);
    endtask

    task automatic t_collide;
        int c;
        wr(4'h8, cw(1, 1, 0), c);
        wr(4'h0, 2, c);
        wr(4'hC, 0, c);   // commits on the expiry edge
        chk("R10 set wins over clear", 32'(irq), 1);
        wr(4'h8, 0, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_dividers();
        t_hold();
        t_periodic();
        t_free();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule